// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Registers

A 32-pin general-purpose I/O controller. The pins are split into two banks of sixteen, and each bank has its own copy of six control registers: output level, output drive enable, input enable, two output-alternate selects and one input-alternate select. A write to any control register does not carry plain data. The low half of the write word marks bits to set and the high half marks bits to clear. Software can therefore flip one pin's setting with a single write and never has to read the register first.

A seventh register per bank returns the pin levels after a two-flop synchronizer. The pad drive enable for a pin is asserted only when its drive enable is set and neither output-alternate select is set. Pins 23, 29, 30 and 31 are reserved. Their bits are tied to zero everywhere.

Top module: `gpio_setclr_bank`

## Requirements
- R1: Bit 7 of the byte address selects the bank. Addresses 0x00–0x18 reach pins 0–15 and 0x80–0x98 reach pins 16–31. Register offsets within a bank are: 0x00 output level, 0x04 drive enable, 0x08 input enable, 0x0C alternate-output select 1, 0x10 alternate-output select 2, 0x14 alternate-input select, 0x18 pin level (read-only).
- R2: On a write to a control register, a 1 in write bit n (n < 16) sets bank bit n, and a 1 in write bit n+16 clears bank bit n. Bits written as 0 keep their stored value. The new value is visible on the cycle after the write edge.
- R3: When the same bank bit is both set and cleared in one write, the result is 0.
- R4: Every register read returns the bank's 16 bits in data bits 15:0 and zeros in bits 31:16.
- R5: The pin-level register shows each pin input through two flops. A change on a pin appears on the second rising edge after it is applied.
- R6: Pins 23, 29, 30 and 31 always read 0 in every register. Writes to them are ignored, and their pad output and drive enable stay 0.
- R7: pin_out carries the output-level bits. pin_oe[n] is 1 only when drive enable n is 1 and both alternate-output selects n are 0.
- R8: The input-enable and alternate-input bits are stored and read back. They have no effect on pin_out or pin_oe.
- R9: Reset clears every control bit, which leaves all pins undriven with no alternate function.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses or to the pin-level register change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address (bit 7 = bank) |
| bus_wdata | input | 32 | Write word: [15:0] set mask, [31:16] clear mask |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad drive enables |

## Verification
Write words are chosen so that a set-only pattern, a clear-only pattern and a set-and-clear pattern on the same bit each give a different stored value. Each pattern is written to both banks, which shows that the high-bank decode does not disturb the low bank. Drive-enable and alternate-select patterns are overlapped so that each term of the pad-enable gating shows up on its own. An all-ones write and all-ones pin inputs in the high bank expose the reserved positions. A pin change is sampled at each of the two synchronizer edges to pin down the latency.

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter logic [31:0] RESV_MASK = 32'hE080_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe
);
  localparam int NREG = 6;
  localparam logic [6:0] LEVEL_OFS = 7'h18;

  logic [31:0] cfg_q [NREG];
  logic [31:0] sync1_q, sync2_q;
  logic [15:0] bank_sel;

  wire       hi_bank = bus_addr[7];
  wire [6:0] ofs     = bus_addr[6:0];
  wire       cfg_hit = (ofs[1:0] == 2'b00) && (ofs[6:2] < 5'(NREG));

  function automatic logic [31:0] merge(input logic [31:0] old, input logic hi,
                                        input logic [31:0] w);
    logic [31:0] s, c;
    s = hi ? {w[15:0], 16'h0}  : {16'h0, w[15:0]};
    c = hi ? {w[31:16], 16'h0} : {16'h0, w[31:16]};
    return (old | s) & ~c & ~RESV_MASK;
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        cfg_q[r] <= '0;
      else if (bus_wr && cfg_hit && ofs[4:2] == 3'(r))
        cfg_q[r] <= merge(cfg_q[r], hi_bank, bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end

  always_comb begin
    logic [31:0] word;
    word = '0;
    if (ofs == LEVEL_OFS)
      word = sync2_q & ~RESV_MASK;
    else if (cfg_hit)
      for (int r = 0; r < NREG; r++)
        if (ofs[4:2] == 3'(r)) word = cfg_q[r];
    bank_sel = hi_bank ? word[31:16] : word[15:0];
  end

  assign bus_rdata = {16'h0, bank_sel};
  assign pin_out   = cfg_q[0];
  assign pin_oe    = cfg_q[1] & ~cfg_q[3] & ~cfg_q[4];
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk #(
  parameter logic [31:0] RESV_MASK = 32'hE080_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_in,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe
);
  a_r6_resv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe) & RESV_MASK) == 32'h0);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);

  a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00 && bus_wdata[0] && !bus_wdata[16]) |=> pin_out[0]);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00 && bus_wdata[16]) |=> !pin_out[0]);

  a_r7_alt_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0C && bus_wdata[0] && !bus_wdata[16]) |=> !pin_oe[0]);

  a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1) && bus_addr == 8'h18)
      |-> bus_rdata[15:0] == $past(pin_in[15:0], 2));
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.RESV_MASK(RESV_MASK)) u_chk (.*);

// File: tb/sim_gpio_setclr_bank.sv
module sim_gpio_setclr_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  gpio_setclr_bank u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(8'(i * 4), d);        chk("R9 low reg", d, 0);
      rd(8'(8'h80 + i * 4), d); chk("R9 high reg", d, 0);
    end
    chk("R9 pin_out", pin_out, 0);
    chk("R9 pin_oe", pin_oe, 0);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(8'h00, 32'h0000_00A5); rd(8'h00, d); chk("R2 set", d, 32'hA5);
    wr(8'h00, 32'h0001_0000); rd(8'h00, d); chk("R2 clear bit0", d, 32'hA4);
    wr(8'h00, 32'h0000_0002); rd(8'h00, d); chk("R2 set bit1", d, 32'hA6);
    wr(8'h00, 32'h0002_0002); rd(8'h00, d); chk("R3 clear wins", d, 32'hA4);
    wr(8'h00, 32'h0008_0008); rd(8'h00, d); chk("R3 clear wins from zero", d, 32'hA4);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R4 upper zero and clear wins", d, 0);
    wr(8'h00, 32'h0000_F0A4); rd(8'h00, d); chk("R4 read half", d, 32'h0000_F0A4);
  endtask

  task automatic t_bank;
    logic [31:0] d;
    wr(8'h80, 32'h0000_0003);
    rd(8'h80, d); chk("R1 high bank read", d, 32'h3);
    rd(8'h00, d); chk("R1 low bank kept", d, 32'hF0A4);
    chk("R1 pin_out map", pin_out, 32'h0003_F0A4);
  endtask

  task automatic t_drive;
    logic [31:0] d;
    wr(8'h04, 32'h0000_00FF); chk("R7 oe", pin_oe, 32'h0000_00FF);
    wr(8'h0C, 32'h0000_0001); chk("R7 alt1 blocks", pin_oe, 32'h0000_00FE);
    wr(8'h10, 32'h0000_0002); chk("R7 alt2 blocks", pin_oe, 32'h0000_00FC);
    wr(8'h0C, 32'h0001_0000); chk("R7 alt1 released", pin_oe, 32'h0000_00FD);
    wr(8'h08, 32'h0000_FFFF); rd(8'h08, d); chk("R8 in_en stored", d, 32'hFFFF);
    wr(8'h14, 32'h0000_0F00); rd(8'h14, d); chk("R8 alt_in stored", d, 32'h0F00);
    chk("R8 oe untouched", pin_oe, 32'h0000_00FD);
    chk("R8 out untouched", pin_out, 32'h0003_F0A4);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(8'h80, 32'h0000_FFFF); rd(8'h80, d); chk("R6 out reserved", d, 32'h1F7F);
    wr(8'h84, 32'h0000_FFFF); rd(8'h84, d); chk("R6 oe reserved", d, 32'h1F7F);
    chk("R6 pin_oe high", pin_oe[31:16], 32'h1F7F);
    chk("R6 pin_out high", pin_out[31:16], 32'h1F7F);
    @(negedge clk) pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(8'h98, d); chk("R6 level reserved", d, 32'h1F7F);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk) pin_in = '0;
    repeat (3) @(negedge clk);
    bus_addr = 8'h18;
    pin_in = 32'h1234_5678;
    @(negedge clk); rd(8'h18, d); chk("R5 one edge old", d, 0);
    @(negedge clk); rd(8'h18, d); chk("R5 two edges new", d, 32'h5678);
    rd(8'h98, d); chk("R5 high level", d, 32'h1234);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h1C, d); chk("R10 unmapped read", d, 0);
    rd(8'h9C, d); chk("R10 unmapped high read", d, 0);
    wr(8'h1C, 32'h0000_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 out kept", d, 32'hF0A4);
    rd(8'h04, d); chk("R10 oe kept", d, 32'h00FF);
    rd(8'h18, d); chk("R10 level kept", d, 32'h5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_bank();
    t_drive();
    t_reserved();
    t_sync();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule